// File: doc/BRIEF.md
# Scaled-Counter PWM Generator with Register Port

This block produces four active-low pulse-width outputs from one shared free-running counter. Before it reaches the comparators, the counter is shifted right by a programmable amount. This sets the period to a power of two of the clock: the 16-bit compare window spans 2^(16+shift) clock ticks. Each channel holds a 16-bit threshold. Its output is pulled low while the windowed count is below that threshold and released high for the rest of the period.

Software controls the block through a small word-addressed register port. Reads are combinational, and a write is accepted on any clock where at least one byte strobe is set. The counter can run continuously, or run once and stop by itself at the next period boundary. It can also be made to restart early when the windowed count meets the first channel's threshold. No register is shadowed, so a threshold or shift written in the middle of a period acts from the next clock.

Top module: `scaled_pwm_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register and the counter read 0 and all four outputs are high (pwm_n = 4'hF).
- R2: The settings word at offset 0x00 keeps only bits [3:0] (shift), 8, 9 (early restart), 10, 12 (continuous run), 13 (run once), 16, 24 and 28, and other bits read 0. Only the byte lanes whose bus_wstrb bit is set are written.
- R3: The raw counter (read at 0x08) increases by one on every clock while bit 12 or bit 13 is set. It holds its value while both are clear.
- R4: Offset 0x10 reads the raw counter shifted right by the shift field. The low 16 bits of this value form the compare window.
- R5: Threshold n is at offset 0x20 + 4*n (n = 0..3, 16 bits wide, upper read bits 0). pwm_n[n] is low exactly while the compare window is below threshold n, so a threshold of 0 keeps the output high.
- R6: A threshold of 0xFFFF leaves the output high only when the window value is 0xFFFF, so one windowed tick per period is always inactive.
- R7: With bit 9 clear, the counter wraps naturally. Starting from 0 at shift 0, the window returns to 0 after 65536 ticks, which is a period of 2^(16+shift) ticks.
- R8: With bit 13 set, the counter advances until the next period boundary. This is the clock where the window is all ones, or an early restart. On that clock the block clears bit 13, and the counter then holds.
- R9: With bit 9 set and the counter advancing, the raw counter becomes 0 on the clock after the window value equals threshold 0.
- R10: Threshold and shift writes change the outputs and the shifted read from the clock after the write, with no wait for a period boundary.
- R11: Reads of any offset other than 0x00, 0x08, 0x10 and 0x20..0x2C (word-aligned) return 0. Writes there are ignored, and the counter offsets cannot be written.
- R12: Bits 8, 10, 16, 24 and 28 are stored but change neither the counter nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write strobes; any set bit makes a write |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_n | output | 4 | Active-low channel outputs |

## Verification
A write is captured on the first rising edge after it is driven. Register reads and outputs reflect it as soon as that edge has passed, so each scoreboard entry is queued one cycle after the write ends and compared at the falling edge of that cycle. The counter moves on every edge where a run bit was set before the edge. A run window made of a start write, n idle cycles and a stop write therefore adds exactly n+2, and the expected counts are derived from this, with early restart reducing the total modulo threshold 0 plus one. A run-once step is expected to end on the edge that follows the write, and bit 13 is read back a few cycles into a longer run-once before it is read again after the boundary.

// File: rtl/spwm_pkg.sv
// Shared constants of the scaled-counter PWM unit: widths, register
// offsets and settings-word bit positions. Assumes a byte-offset bus
// with 32-bit word-aligned registers.
package spwm_pkg;
    localparam int SPWM_CMP_W   = 16;
    localparam int SPWM_SHIFT_W = 4;
    localparam int SPWM_NCH     = 4;
    localparam int SPWM_AW      = 8;
    localparam int SPWM_DW      = 32;

    localparam int B_KEEP  = 8;
    localparam int B_ZRST  = 9;
    localparam int B_DGL   = 10;
    localparam int B_RUN   = 12;
    localparam int B_ONCE  = 13;
    localparam int B_CTR   = 16;
    localparam int B_GRP   = 24;
    localparam int B_IRQ   = 28;

    localparam logic [SPWM_DW-1:0] CFG_MASK = 32'h1101_370F;

    localparam logic [SPWM_AW-1:0] OFS_CFG  = 8'h00;
    localparam logic [SPWM_AW-1:0] OFS_RAW  = 8'h08;
    localparam logic [SPWM_AW-1:0] OFS_SCL  = 8'h10;
    localparam logic [SPWM_AW-1:0] OFS_THR0 = 8'h20;
endpackage

// File: rtl/spwm_count.sv
// Free-running counter with shift prescaling. Advances once per clock
// while either run input is high. It restarts at 0 after the window meets
// threshold 0 when early restart is on. It flags each period boundary
// (window all ones, or early restart) so the run-once bit can be cleared.
// Assumes CNT_W = CMP_W + 2^SHIFT_W - 1.
module spwm_count #(
    parameter int CMP_W   = 16,
    parameter int SHIFT_W = 4,
    parameter int CNT_W   = CMP_W + (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_cont,
    input  logic               run_once,
    input  logic               zrst_en,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CMP_W-1:0]   thr0,
    output logic [CNT_W-1:0]   raw_q,
    output logic [CNT_W-1:0]   scaled,
    output logic               boundary
);
    logic               adv;
    logic               zhit;
    logic               at_top;
    logic [CNT_W-1:0]   win_mask;
    logic [SHIFT_W-1:0] inv_shift;

    // Decode advance, window mask and the two period-end conditions.
    always_comb begin
        adv       = run_cont | run_once;
        inv_shift = ~shift;
        win_mask  = {CNT_W{1'b1}} >> inv_shift;
        scaled    = raw_q >> shift;
        at_top    = &(raw_q | ~win_mask);
        zhit      = zrst_en && (scaled[CMP_W-1:0] == thr0);
        boundary  = adv && (zhit || at_top);
    end

    // Counter register: step, early restart or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else if (adv)
            raw_q <= zhit ? '0 : raw_q + 1'b1;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_cont && !run_once) |=> $stable(raw_q));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cont && !zrst_en) |=> (raw_q == $past(raw_q) + 1'b1));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cont || run_once) && zrst_en && (scaled[CMP_W-1:0] == thr0))
        |=> (raw_q == '0));
endmodule

// File: rtl/spwm_chan.sv
// One compare channel: drives its active-low output low while the
// window count is below its threshold. Purely combinational; the clock
// and reset only serve the local checks.
module spwm_chan #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] window,
    input  logic [CMP_W-1:0] thr,
    output logic             out_n
);
    // Compare window against threshold.
    always_comb out_n = !(window < thr);

    p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0) |-> out_n);

    p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr == {CMP_W{1'b1}}) && (window != {CMP_W{1'b1}})) |-> !out_n);
endmodule

// File: rtl/spwm_regs.sv
// Register file: the settings word, per-channel thresholds, byte-lane
// writes and the combinational read mux. Clears the run-once bit at a
// period boundary; a write in that same cycle wins. Assumes word-aligned
// offsets and that counter offsets are read-only.
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CMP_W = 16,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CNT_W = 31
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    input  logic [DW/8-1:0]            bus_wstrb,
    output logic [DW-1:0]              bus_rdata,
    input  logic [CNT_W-1:0]           raw,
    input  logic [CNT_W-1:0]           scaled,
    input  logic                       boundary,
    output logic [DW-1:0]              cfg_q,
    output logic [NCH-1:0][CMP_W-1:0]  thr_q
);
    localparam int NB  = DW / 8;
    localparam int TNB = CMP_W / 8;

    logic [DW-1:0]  cfg_merged;
    logic           wr_cfg;
    logic [NCH-1:0] wr_thr;

    // Address decode for writes and byte-lane merge of the settings word.
    always_comb begin
        wr_cfg = (bus_wstrb != '0) && (bus_addr == OFS_CFG);
        for (int n = 0; n < NCH; n++)
            wr_thr[n] = (bus_wstrb != '0) && (bus_addr == OFS_THR0 + AW'(4 * n));
        cfg_merged = cfg_q;
        for (int b = 0; b < NB; b++)
            if (bus_wstrb[b]) cfg_merged[8*b +: 8] = bus_wdata[8*b +: 8];
    end

    // Settings word storage with hardware clear of the run-once bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_cfg)
            cfg_q <= cfg_merged & CFG_MASK;
        else if (boundary)
            cfg_q[B_ONCE] <= 1'b0;
    end

    // Threshold storage, one register per channel.
    for (genvar n = 0; n < NCH; n++) begin : g_thr
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_q[n] <= '0;
            else if (wr_thr[n])
                for (int b = 0; b < TNB; b++)
                    if (bus_wstrb[b]) thr_q[n][8*b +: 8] <= bus_wdata[8*b +: 8];
        end
    end

    // Read mux; unknown offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CFG)      bus_rdata = cfg_q;
        else if (bus_addr == OFS_RAW) bus_rdata = DW'(raw);
        else if (bus_addr == OFS_SCL) bus_rdata = DW'(scaled);
        else
            for (int n = 0; n < NCH; n++)
                if (bus_addr == OFS_THR0 + AW'(4 * n)) bus_rdata = DW'(thr_q[n]);
    end

    p_once_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && cfg_q[B_ONCE] && (bus_wstrb == '0)) |=> !cfg_q[B_ONCE]);

    p_thr_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == OFS_THR0) && (bus_wstrb[TNB-1:0] == {TNB{1'b1}}))
        |=> (thr_q[0] == $past(bus_wdata[CMP_W-1:0])));

    p_undef_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

// File: rtl/scaled_pwm_unit.sv
// Top of the scaled-counter PWM unit: a register file, one shared
// prescaled counter and a row of compare channels. Outputs are active-low
// and follow register state without shadowing.
module scaled_pwm_unit
    import spwm_pkg::*;
#(
    parameter int NCH     = SPWM_NCH,
    parameter int CMP_W   = SPWM_CMP_W,
    parameter int SHIFT_W = SPWM_SHIFT_W,
    parameter int AW      = SPWM_AW,
    parameter int DW      = SPWM_DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [DW/8-1:0] bus_wstrb,
    output logic [DW-1:0]   bus_rdata,
    output logic [NCH-1:0]  pwm_n
);
    localparam int CNT_W = CMP_W + (1 << SHIFT_W) - 1;

    logic [DW-1:0]             cfg_q;
    logic [NCH-1:0][CMP_W-1:0] thr_q;
    logic [CNT_W-1:0]          raw;
    logic [CNT_W-1:0]          scaled;
    logic                      boundary;

    spwm_regs #(.NCH(NCH), .CMP_W(CMP_W), .AW(AW), .DW(DW), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata), .raw(raw), .scaled(scaled),
        .boundary(boundary), .cfg_q(cfg_q), .thr_q(thr_q)
    );

    spwm_count #(.CMP_W(CMP_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n), .run_cont(cfg_q[B_RUN]), .run_once(cfg_q[B_ONCE]),
        .zrst_en(cfg_q[B_ZRST]), .shift(cfg_q[SHIFT_W-1:0]), .thr0(thr_q[0]),
        .raw_q(raw), .scaled(scaled), .boundary(boundary)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        spwm_chan #(.CMP_W(CMP_W)) chan_i (
            .clk(clk), .rst_n(rst_n), .window(scaled[CMP_W-1:0]),
            .thr(thr_q[n]), .out_n(pwm_n[n])
        );
    end

    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |=> (pwm_n == '1));
endmodule

// File: tb/scaled_pwm_unit_tb_top.sv
module scaled_pwm_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        bit          is_pwm;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    localparam logic [7:0] A_CFG = 8'h00, A_RAW = 8'h08, A_SCL = 8'h10, A_T0 = 8'h20,
                           A_T1 = 8'h24, A_T2 = 8'h28, A_T3 = 8'h2C;
    localparam logic [31:0] RUN = 32'h1000, ONCE = 32'h2000, ZRST = 32'h0200;

    always #10 clk = ~clk;

    scaled_pwm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata), .pwm_n(pwm_n)
    );

    // Monitor: compares one queued expectation at each falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_pwm ? {28'h0, pwm_n} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(posedge clk); #2;
        bus_wstrb = '0;
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #2;
        bus_addr = a;
        sb_q.push_back('{tag: tag, is_pwm: 1'b0, exp: e});
    endtask

    task automatic exp_pwm(input logic [3:0] e, input string tag);
        @(posedge clk); #2;
        sb_q.push_back('{tag: tag, is_pwm: 1'b1, exp: {28'h0, e}});
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Counter advances n+2 times: start write, n idle cycles, stop write.
    task automatic run_for(input logic [31:0] cfg, input int n);
        wr(A_CFG, cfg | RUN, 4'hF);
        idle(n);
        wr(A_CFG, cfg, 4'hF);
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        idle(3); #2;
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        exp_rd(A_CFG, 32'h0, "R1 cfg");
        exp_rd(A_RAW, 32'h0, "R1 raw");
        exp_rd(A_SCL, 32'h0, "R1 scaled");
        exp_rd(A_T0, 32'h0, "R1 thr0");
        exp_rd(A_T3, 32'h0, "R1 thr3");
        exp_pwm(4'hF, "R1 outputs");

        // R2 stored bits and byte lanes
        wr(A_CFG, 32'hFFFF_CFFF, 4'hF);
        exp_rd(A_CFG, 32'h1101_070F, "R2 mask");
        wr(A_CFG, 32'h0, 4'b0001);
        exp_rd(A_CFG, 32'h1101_0700, "R2 byte lane");
        wr(A_CFG, 32'h0, 4'hF);
        wr(A_T1, 32'hABCD_1234, 4'hF);
        exp_rd(A_T1, 32'h0000_1234, "R5 thr width");

        // R11 undefined offsets and read-only counter
        wr(8'h04, 32'hFFFF_FFFF, 4'hF);
        wr(8'h0C, 32'hFFFF_FFFF, 4'hF);
        wr(8'h30, 32'hFFFF_FFFF, 4'hF);
        wr(8'h21, 32'hFFFF_FFFF, 4'hF);
        wr(A_RAW, 32'hFFFF_FFFF, 4'hF);
        exp_rd(8'h04, 32'h0, "R11 read 04");
        exp_rd(8'h30, 32'h0, "R11 read 30");
        exp_rd(8'h21, 32'h0, "R11 read 21");
        exp_rd(A_RAW, 32'h0, "R11 raw unwritten");
        exp_rd(A_CFG, 32'h0, "R11 cfg untouched");
        exp_rd(A_T0, 32'h0, "R11 thr0 untouched");
        exp_rd(A_T1, 32'h0000_1234, "R11 thr1 untouched");

        // R3 run and hold
        run_for(32'h0, 10);
        exp_rd(A_RAW, 32'd12, "R3 counted");
        idle(5);
        exp_rd(A_RAW, 32'd12, "R3 hold");
        exp_rd(A_SCL, 32'd12, "R4 shift0");

        // R4 shifted read, R10 immediate shift
        wr(A_CFG, 32'h2, 4'hF);
        exp_rd(A_SCL, 32'd3, "R4 shift2");
        wr(A_CFG, 32'h3, 4'hF);
        exp_rd(A_SCL, 32'd1, "R4 shift3");
        exp_rd(A_RAW, 32'd12, "R4 raw kept");

        // R5 compare outputs, R10 immediate threshold
        wr(A_CFG, 32'h0, 4'hF);
        wr(A_T0, 32'd5, 4'hF);
        wr(A_T1, 32'd3, 4'hF);
        wr(A_T3, 32'hFFFF, 4'hF);
        exp_pwm(4'b0111, "R5 window12");
        wr(A_T1, 32'd13, 4'hF);
        exp_pwm(4'b0101, "R10 thr change");
        wr(A_CFG, 32'h2, 4'hF);
        exp_pwm(4'b0100, "R10 shift change");

        // R12 inert bits
        wr(A_CFG, 32'h1101_0502, 4'hF);
        exp_pwm(4'b0100, "R12 outputs");
        idle(5);
        exp_rd(A_RAW, 32'd12, "R12 counter");

        // Second reset, then R6 / R7 / R8
        do_reset();
        exp_rd(A_RAW, 32'h0, "R1 raw after reset");
        exp_pwm(4'hF, "R1 outputs after reset");
        wr(A_T3, 32'hFFFF, 4'hF);
        run_for(32'h0, 65533);
        exp_rd(A_RAW, 32'h0000_FFFF, "R7 raw top");
        exp_pwm(4'hF, "R6 inactive at top");
        wr(A_CFG, ONCE, 4'hF);
        exp_rd(A_RAW, 32'h0001_0000, "R7 wrap");
        exp_rd(A_CFG, 32'h0, "R8 once cleared");
        exp_pwm(4'b0111, "R7 window zero");
        idle(4);
        exp_rd(A_RAW, 32'h0001_0000, "R8 holds");

        // R9 early restart ends a run-once, R8 bit live mid-run
        wr(A_T0, 32'd9, 4'hF);
        wr(A_CFG, ONCE | ZRST, 4'hF);
        exp_rd(A_CFG, ONCE | ZRST, "R8 once running");
        idle(20);
        exp_rd(A_RAW, 32'h0, "R9 restart");
        exp_rd(A_CFG, ZRST, "R8 cleared at restart");

        // R9 continuous with early restart: 12 steps modulo 5
        wr(A_T0, 32'd4, 4'hF);
        run_for(ZRST, 10);
        exp_rd(A_RAW, 32'd2, "R9 modulo");
        exp_pwm(4'b0110, "R9 outputs");

        idle(3);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule